// File: doc/BRIEF.md
# CCD Line Transfer and Readout Sequencer

This block produces every digital clock phase that a full-frame CCD with two horizontal shift registers needs to move and read one frame. After a start command it loads rows from the vertical register into horizontal register A, moves them into register B through the transfer gate when the paired mode is selected, and then clocks the horizontal phases. Each line is read from its centre toward both ends at once, so two or four outputs carry data. It also produces a one-cycle sample strobe for an external converter, and it pulses the sense-node reset after every sample.

All counts are sampled when the frame starts. These are the row count, the image pixels per half-line, the leading dark pixels per half-line, and the vertical and horizontal phase widths in clock cycles. Changes to these inputs during a frame have no effect. The block produces only timing: analog levels, bias and sample arithmetic are handled elsewhere. With a clock of four times the pixel rate and a horizontal width of 2, the pixel period is four cycles. A pixel rate within 18 MHz and a full frame of 8304 columns by 6220 rows fit the default widths.

Top module: `ccd_seq`

## Requirements
- R1: After reset and while idle, every phase output, `sample`, `pix_dark`, `out_en`, `frame_done` and `busy` is low.
- R2: When `start` is seen while idle, all counts and the mode are captured, and `busy` is high from the next cycle through the `frame_done` cycle. A `start` pulse or a change of counts while busy has no effect on any output.
- R3: A row transfer lasts 3×`vph` cycles. `v1` is high for the first `vph` cycles, then `v2` is high for `vph` cycles, then both are low for `vph` cycles. `h1a` is high for the whole transfer, so `v2` falls only while `h1a` is high.
- R4: With `par_mode`=0, each row transfer is followed directly by a readout of register A. During that readout `out_en`=4'b0011 (bit 0 left A, bit 1 right A) and only `h1a` is clocked.
- R5: With `par_mode`=1, a row transfer is followed by a `vph`-cycle transfer-gate pulse with `h1b` high and `h1a` low. Then the next row transfer follows, and both registers are read together with `out_en`=4'b1111 (bit 2 left B, bit 3 right B), with `h1a` and `h1b` both clocked.
- R6: With `par_mode`=1 and an odd row count, the last row is transferred and gated into B. It is then flushed alone with `out_en`=4'b1100, `h1b` clocked and `h1a` low.
- R7: A pixel period is 2×`hph` cycles. The clocked H1 phases are high for the first `hph` cycles and `h2` is high for the remaining `hph` cycles. `h2` is never high together with any H1 phase.
- R8: `h1l` follows the clocked H1 phase, so it has exactly one falling edge per pixel and `dark_pix`+`half_pix` falling edges per readout.
- R9: `sample` is high for exactly one cycle per pixel, in the cycle in which `h1l` has just fallen (cycle index `hph` of the period). `rg` is high in the last cycle of the period and never together with `sample`.
- R10: `pix_dark` is high during the first `dark_pix` pixel periods of each readout and low during the image pixels.
- R11: After the last readout, `frame_done` is high for one cycle, and the block is idle in the next cycle.
- R12: `xg` is high only while both `v1` and `v2` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Start-of-frame command, used only while idle |
| par_mode | input | 1 | 0: one register read per row; 1: paired rows in A and B |
| rows | input | ROW_W | Rows per frame (at least 1) |
| half_pix | input | PIX_W | Image pixels per half-line (at least 1) |
| dark_pix | input | PIX_W | Leading dark/overscan pixels per half-line |
| vph | input | PH_W | Vertical phase width in cycles (at least 1) |
| hph | input | PH_W | Horizontal half-period in cycles (at least 2) |
| v1 | output | 1 | Vertical phase 1 |
| v2 | output | 1 | Vertical phase 2 |
| h1a | output | 1 | Horizontal phase 1, register A |
| h1b | output | 1 | Horizontal phase 1, register B |
| h2 | output | 1 | Horizontal phase 2 |
| h1l | output | 1 | Last-gate horizontal phase |
| xg | output | 1 | Transfer gate between registers A and B |
| rg | output | 1 | Sense-node reset gate |
| sample | output | 1 | Converter sample strobe |
| pix_dark | output | 1 | Current pixel is a dark/overscan pixel |
| out_en | output | 4 | Active outputs: {right B, left B, right A, left A} |
| frame_done | output | 1 | One-cycle end-of-frame pulse |
| busy | output | 1 | Frame in progress |

## Verification
The hardest case to reach is the lone final line in paired mode, because it appears only when the captured row count is odd. The stimulus runs paired frames with three rows and with one row, and it compares those frames against a paired frame with four rows. A second hard case is proving that the configuration is held. For this, some frames pulse `start` again mid-frame while the count inputs are changed, and the bench then checks that the cycle-by-cycle output trace still matches the values captured at the start.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;

  typedef enum logic [2:0] {
    SEG_IDLE,
    SEG_VX,
    SEG_XG,
    SEG_RD,
    SEG_DONE
  } seg_e;

  // pixel periods in one readout: dark lead-in plus image pixels
  function automatic int unsigned line_pixels(input int unsigned dark, input int unsigned half);
    return dark + half;
  endfunction

  // cycles of one pixel period
  function automatic int unsigned pixel_span(input int unsigned hph);
    return 2 * hph;
  endfunction

endpackage

// File: rtl/ccd_vclk_gen.sv
module ccd_vclk_gen #(
  parameter int PH_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [PH_W-1:0] vph,
  output logic            v1,
  output logic            v2,
  output logic            last
);
  logic [1:0]      step_q;
  logic [PH_W-1:0] cnt_q;
  logic            step_end;

  assign step_end = (cnt_q == vph - PH_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      cnt_q  <= '0;
    end else if (!en) begin
      step_q <= '0;
      cnt_q  <= '0;
    end else if (step_end) begin
      cnt_q  <= '0;
      step_q <= step_q + 2'd1;
    end else begin
      cnt_q <= cnt_q + PH_W'(1);
    end
  end

  assign v1   = en && (step_q == 2'd0);
  assign v2   = en && (step_q == 2'd1);
  assign last = en && (step_q == 2'd2) && step_end;
endmodule

// File: rtl/ccd_hclk_gen.sv
module ccd_hclk_gen #(
  parameter int PIX_W = 13,
  parameter int PH_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [PH_W-1:0]  hph,
  input  logic [PIX_W-1:0] npix,
  input  logic [PIX_W-1:0] ndark,
  output logic             h1,
  output logic             h2,
  output logic             sample,
  output logic             rg,
  output logic             dark,
  output logic             last
);
  localparam int CYC_W = PH_W + 1;

  logic [CYC_W-1:0] cyc_q;
  logic [PIX_W-1:0] pix_q;
  logic [CYC_W-1:0] span_m1;
  logic [CYC_W-1:0] half_c;
  logic             period_end;

  assign half_c     = {1'b0, hph};
  assign span_m1    = {hph, 1'b0} - CYC_W'(1);
  assign period_end = (cyc_q == span_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q <= '0;
      pix_q <= '0;
    end else if (!en) begin
      cyc_q <= '0;
      pix_q <= '0;
    end else if (period_end) begin
      cyc_q <= '0;
      pix_q <= pix_q + PIX_W'(1);
    end else begin
      cyc_q <= cyc_q + CYC_W'(1);
    end
  end

  assign h1     = en && (cyc_q < half_c);
  assign h2     = en && (cyc_q >= half_c);
  assign sample = en && (cyc_q == half_c);
  assign rg     = en && period_end;
  assign dark   = en && (pix_q < ndark);
  assign last   = en && period_end && (pix_q == npix - PIX_W'(1));
endmodule

// File: rtl/ccd_seq.sv
module ccd_seq
  import ccd_seq_pkg::*;
#(
  parameter int ROW_W = 13,
  parameter int PIX_W = 13,
  parameter int PH_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             par_mode,
  input  logic [ROW_W-1:0] rows,
  input  logic [PIX_W-1:0] half_pix,
  input  logic [PIX_W-1:0] dark_pix,
  input  logic [PH_W-1:0]  vph,
  input  logic [PH_W-1:0]  hph,
  output logic             v1,
  output logic             v2,
  output logic             h1a,
  output logic             h1b,
  output logic             h2,
  output logic             h1l,
  output logic             xg,
  output logic             rg,
  output logic             sample,
  output logic             pix_dark,
  output logic [3:0]       out_en,
  output logic             frame_done,
  output logic             busy
);
  seg_e             seg_q;
  logic             par_q, second_q, rd_a_q, rd_b_q;
  logic [ROW_W-1:0] left_q;
  logic [PIX_W-1:0] npix_q, dark_q;
  logic [PH_W-1:0]  vph_q, hph_q, xg_cnt_q;

  // named internal events
  logic row_loaded, line_read, gate_done;
  logic h1_g, h2_g, smp_g, rg_g, dark_g;

  ccd_vclk_gen #(.PH_W(PH_W)) u_vclk (
    .clk(clk), .rst_n(rst_n), .en(seg_q == SEG_VX), .vph(vph_q),
    .v1(v1), .v2(v2), .last(row_loaded)
  );

  ccd_hclk_gen #(.PIX_W(PIX_W), .PH_W(PH_W)) u_hclk (
    .clk(clk), .rst_n(rst_n), .en(seg_q == SEG_RD), .hph(hph_q),
    .npix(npix_q), .ndark(dark_q),
    .h1(h1_g), .h2(h2_g), .sample(smp_g), .rg(rg_g), .dark(dark_g), .last(line_read)
  );

  assign gate_done = (seg_q == SEG_XG) && (xg_cnt_q == vph_q - PH_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                xg_cnt_q <= '0;
    else if (seg_q != SEG_XG)  xg_cnt_q <= '0;
    else                       xg_cnt_q <= xg_cnt_q + PH_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q    <= SEG_IDLE;
      par_q    <= 1'b0;
      second_q <= 1'b0;
      rd_a_q   <= 1'b0;
      rd_b_q   <= 1'b0;
      left_q   <= '0;
      npix_q   <= '0;
      dark_q   <= '0;
      vph_q    <= '0;
      hph_q    <= '0;
    end else begin
      case (seg_q)
        SEG_IDLE: if (start) begin
          par_q    <= par_mode;
          left_q   <= rows;
          npix_q   <= PIX_W'(line_pixels(int'(dark_pix), int'(half_pix)));
          dark_q   <= dark_pix;
          vph_q    <= vph;
          hph_q    <= hph;
          second_q <= 1'b0;
          rd_a_q   <= 1'b0;
          rd_b_q   <= 1'b0;
          seg_q    <= SEG_VX;
        end
        SEG_VX: if (row_loaded) begin
          left_q <= left_q - ROW_W'(1);
          if (!par_q) begin
            seg_q  <= SEG_RD;
            rd_a_q <= 1'b1;
            rd_b_q <= 1'b0;
          end else if (!second_q) begin
            seg_q <= SEG_XG;
          end else begin
            seg_q  <= SEG_RD;
            rd_a_q <= 1'b1;
            rd_b_q <= 1'b1;
          end
        end
        SEG_XG: if (gate_done) begin
          if (left_q == '0) begin
            seg_q  <= SEG_RD;
            rd_a_q <= 1'b0;
            rd_b_q <= 1'b1;
          end else begin
            seg_q    <= SEG_VX;
            second_q <= 1'b1;
          end
        end
        SEG_RD: if (line_read) begin
          second_q <= 1'b0;
          rd_a_q   <= 1'b0;
          rd_b_q   <= 1'b0;
          seg_q    <= (left_q == '0) ? SEG_DONE : SEG_VX;
        end
        SEG_DONE: seg_q <= SEG_IDLE;
        default:  seg_q <= SEG_IDLE;
      endcase
    end
  end

  assign h1a        = (seg_q == SEG_VX) || (rd_a_q && h1_g);
  assign h1b        = (seg_q == SEG_XG) || (rd_b_q && h1_g);
  assign h1l        = h1_g;
  assign h2         = h2_g;
  assign xg         = (seg_q == SEG_XG);
  assign rg         = rg_g;
  assign sample     = smp_g;
  assign pix_dark   = dark_g;
  assign out_en     = {rd_b_q, rd_b_q, rd_a_q, rd_a_q};
  assign frame_done = (seg_q == SEG_DONE);
  assign busy       = (seg_q != SEG_IDLE);
endmodule

// File: rtl/ccd_seq_chk.sv
module ccd_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       v1,
  input logic       v2,
  input logic       h1a,
  input logic       h1b,
  input logic       h2,
  input logic       h1l,
  input logic       xg,
  input logic       rg,
  input logic       sample,
  input logic [3:0] out_en,
  input logic       frame_done,
  input logic       busy
);
  // R3
  v2_fall_h1a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(v2) |-> h1a);

  // R7
  h_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    h2 |-> !(h1a || h1b || h1l));

  // R9
  sample_rg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample && rg));

  // R9
  h1l_fall_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(h1l) |-> sample);

  // R12
  xg_vert_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xg |-> (!v1 && !v2));

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> (!busy && !frame_done));

  // R4
  sample_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample |-> (out_en != 4'b0000));
endmodule

bind ccd_seq ccd_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .v1(v1), .v2(v2), .h1a(h1a), .h1b(h1b),
  .h2(h2), .h1l(h1l), .xg(xg), .rg(rg), .sample(sample), .out_en(out_en),
  .frame_done(frame_done), .busy(busy)
);

// File: tb/ccd_seq_test.sv
module ccd_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int ROW_W = 13;
  localparam int PIX_W = 13;
  localparam int PH_W  = 6;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic             par_mode = 1'b0;
  logic [ROW_W-1:0] rows = '0;
  logic [PIX_W-1:0] half_pix = '0;
  logic [PIX_W-1:0] dark_pix = '0;
  logic [PH_W-1:0]  vph = '0;
  logic [PH_W-1:0]  hph = '0;
  logic v1, v2, h1a, h1b, h2, h1l, xg, rg, sample, pix_dark, frame_done, busy;
  logic [3:0] out_en;

  int checks = 0;
  int fails  = 0;
  logic [15:0] expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ccd_seq #(.ROW_W(ROW_W), .PIX_W(PIX_W), .PH_W(PH_W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .par_mode(par_mode), .rows(rows),
    .half_pix(half_pix), .dark_pix(dark_pix), .vph(vph), .hph(hph),
    .v1(v1), .v2(v2), .h1a(h1a), .h1b(h1b), .h2(h2), .h1l(h1l), .xg(xg),
    .rg(rg), .sample(sample), .pix_dark(pix_dark), .out_en(out_en),
    .frame_done(frame_done), .busy(busy)
  );

  // bit map: 0 v1,1 v2,2 h1a,3 h1b,4 h2,5 h1l,6 xg,7 rg,8 sample,9 pix_dark,13:10 out_en,14 done,15 busy
  function automatic logic [15:0] actual();
    return {busy, frame_done, out_en, pix_dark, sample, rg, xg, h1l, h2, h1b, h1a, v2, v1};
  endfunction

  function automatic string tag_of(input int b, input bit par);
    case (b)
      0, 1:         return "R3";
      2, 3, 10, 11, 12, 13: return par ? "R5" : "R4";
      4:            return "R7";
      5:            return "R8";
      6:            return "R12";
      7, 8:         return "R9";
      9:            return "R10";
      14:           return "R11";
      default:      return "R2";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push_vx(input int v);
    for (int s = 0; s < 3; s++)
      for (int c = 0; c < v; c++) begin
        logic [15:0] e = 16'h8004;
        e[0] = (s == 0);
        e[1] = (s == 1);
        expq.push_back(e);
      end
  endtask

  task automatic push_xg(input int v);
    for (int c = 0; c < v; c++) expq.push_back(16'h8048);
  endtask

  task automatic push_rd(input bit a, input bit b, input int d, input int h, input int w);
    for (int p = 0; p < d + h; p++)
      for (int c = 0; c < 2 * w; c++) begin
        logic [15:0] e = 16'h8000;
        bit hi = (c < w);
        e[2] = a & hi;
        e[3] = b & hi;
        e[4] = !hi;
        e[5] = hi;
        e[7] = (c == 2 * w - 1);
        e[8] = (c == w);
        e[9] = (p < d);
        e[13:10] = {b, b, a, a};
        expq.push_back(e);
      end
  endtask

  task automatic run_frame(input int r, input bit p, input int h, input int d,
                           input int v, input int w, input int poke);
    int rem = r;
    int reads = 0;
    int falls = 0;
    int dark_smp = 0;
    int bonly = 0;
    int idx = 0;
    bit prev_h1l = 0;
    bit prev_v2 = 0;
    logic [15:0] e, a;
    expq.delete();
    if (!p) begin
      for (int i = 0; i < r; i++) begin push_vx(v); push_rd(1, 0, d, h, w); reads++; end
    end else begin
      while (rem > 0) begin
        push_vx(v); push_xg(v); rem--;
        if (rem > 0) begin push_vx(v); rem--; push_rd(1, 1, d, h, w); end
        else push_rd(0, 1, d, h, w);
        reads++;
      end
    end
    expq.push_back(16'hC000);
    rows = ROW_W'(r); par_mode = p; half_pix = PIX_W'(h); dark_pix = PIX_W'(d);
    vph = PH_W'(v); hph = PH_W'(w);
    @(negedge clk) start = 1'b1;
    @(posedge clk);
    @(negedge clk) start = 1'b0;
    while (expq.size() > 0) begin
      e = expq.pop_front();
      a = actual();
      if (a != e) begin
        int fb = 0;
        for (int b = 15; b >= 0; b--) if (a[b] != e[b]) fb = b;
        check(0, tag_of(fb, p), $sformatf("cycle %0d trace", idx), int'(a), int'(e));
      end else check(1, "R2", "trace", 0, 0);
      if (prev_v2 && !v2) check(h1a, "R3", "v2 fell without h1a", int'(h1a), 1);
      if (prev_h1l && !h1l) falls++;
      if (sample && pix_dark) dark_smp++;
      if (h1l && out_en == 4'b1100) bonly++;
      prev_v2 = v2; prev_h1l = h1l;
      if (idx == poke) begin
        start = 1'b1; rows = ROW_W'(r + 2); half_pix = PIX_W'(h + 1); par_mode = !p;
      end else start = 1'b0;
      @(posedge clk);
      @(negedge clk);
      idx++;
    end
    start = 1'b0;
    check(actual() == 16'h0000, "R11", "idle after frame", int'(actual()), 0);
    check(falls == reads * (d + h), "R8", "h1l falling edges", falls, reads * (d + h));
    check(dark_smp == reads * d, "R10", "dark samples", dark_smp, reads * d);
    if (p && (r % 2 == 1))
      check(bonly == w * (d + h), "R6", "lone B flush h1 cycles", bonly, w * (d + h));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(actual() == 16'h0000, "R1", "state in reset", int'(actual()), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(actual() == 16'h0000, "R1", "idle after reset", int'(actual()), 0);
    run_frame(3, 0, 3, 1, 2, 2, -1);   // R4
    run_frame(4, 1, 2, 2, 1, 3, 5);    // R5, R2 start ignored
    run_frame(3, 1, 4, 0, 3, 2, -1);   // R6
    run_frame(1, 0, 1, 3, 1, 4, 2);    // R4, R2 start ignored
    run_frame(1, 1, 1, 1, 1, 2, -1);   // R6
    run_frame(2, 1, 3, 2, 2, 3, 40);   // R5, R12
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule